// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Character Timeout

This block is the receive side of a 16550-class serial port, placed between a character deserializer and the processor's register interface. Each received character or line-break event is stored in a 16-deep, byte-wide queue. The block serves reads of the receive buffer and keeps the data-ready, overrun and break status flags. It also reports when the fill count reaches a threshold that software selects.

A character-timeout timer runs on a 16x baud tick. When the timer expires, it marks that data has waited in the queue for four character times. The length of one character comes from the low four bits of the line-control word.

A write to the queue-control word does three things: it turns queueing on or off, it empties the receive and transmit queues, and it selects the threshold. When queueing is off, the block acts as a single holding register. The transmit side is outside this block. It only receives a one-cycle flush request.

Top module: `uart_rxq`

## Requirements
- R1: After reset, the fill count, data-ready, overrun, break, trigger and timeout flags are all 0, and the retained control word is 0x00.
- R2: A control write keeps only the bits under mask 0xC9. Bit 0 enables queueing. Bits 7:6 select the threshold. Bit 3 is stored but has no effect here.
- R3: A control write that changes bit 0 empties the receive queue and raises `tx_flush` in the same cycle, whether or not bits 1 and 2 are set. A write with bit 2 set also raises `tx_flush`.
- R4: The threshold select codes map as follows: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. `trig_hit` is high when data is ready and the fill count is at least the selected threshold.
- R5: Reads return bytes in arrival order. When queueing is on, data-ready stays set while the queue holds data, and reading the last byte clears it.
- R6: A character that arrives while the queue holds 16 bytes is dropped and sets overrun. The stored bytes are not changed. A pulse on `lsr_rd` clears overrun and break.
- R7: A break event stores 0x00 and sets both break and data-ready. Break stays set until the last byte is read, the receive queue is reset, or `lsr_rd` is pulsed.
- R8: A read of an empty queue returns 0x00. Every read clears the timeout flag.
- R9: The timeout flag sets once 4 x 16 x F baud ticks have passed with data still queued. F is the frame length in bits: 1 start bit, plus line-control bits 1:0 plus 5 data bits, plus 1 parity bit if bit 3 is set, plus 1 stop bit or 2 if bit 2 is set.
- R10: The timeout window restarts on every arrival, and on every read that leaves data in the queue.
- R11: A control write with bit 1 set empties the queue and clears data-ready, break and the timeout flag.
- R12: With queueing off, one holding register keeps the latest byte. An arrival while data-ready is set sets overrun and replaces the held byte. A read clears data-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | 16x oversample tick that drives the timeout timer |
| line_ctrl | input | 4 | Frame format: [1:0] data bits minus 5, [2] two stop bits, [3] parity present |
| char_valid | input | 1 | Received character strobe |
| char_data | input | 8 | Received character |
| brk_valid | input | 1 | Line-break event strobe |
| rd_en | input | 1 | Read strobe for the receive buffer |
| rd_data | output | 8 | Byte returned during a read |
| lsr_rd | input | 1 | Status read strobe; clears overrun and break |
| fcr_wr | input | 1 | Control word write strobe |
| fcr_data | input | 8 | Control word value |
| fcr_q | output | 8 | Retained control bits |
| tx_flush | output | 1 | One-cycle flush request to the transmit queue |
| data_ready | output | 1 | Receive data available |
| overrun | output | 1 | A character was lost |
| brk_flag | output | 1 | A break was received |
| trig_hit | output | 1 | Fill count has reached the threshold |
| timeout_pend | output | 1 | Character timeout pending |
| fill_count | output | 5 | Bytes held in the queue |

## Verification
The assertions assume that a character strobe and a break strobe never arrive in the same cycle. They also assume that a control write with a flush does not coincide with a read whose result matters. The stimulus drives every strobe for exactly one cycle and never overlaps these events. The timeout checks hold `baud_tick` high on every cycle, so each expiry edge is an exact cycle count from the arming event. The line-control word is changed only while the timer is idle.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'hC9;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_sel_e;

  // Bits per serial frame: start, data, optional parity, stop(s).
  function automatic logic [3:0] frame_bits(input logic [3:0] lc);
    frame_bits = 4'd1 + (4'd5 + {2'b00, lc[1:0]}) + {3'b000, lc[3]}
               + (4'd1 + {3'b000, lc[2]});
  endfunction
endpackage

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
  import uart_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fcr_wr,
  input  logic [BYTE_W-1:0] fcr_data,
  output logic [BYTE_W-1:0] fcr_q,
  output logic              rx_flush,
  output logic              tx_flush
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic              en_toggle;

  always_comb begin
    en_toggle = fcr_data[0] ^ ctrl_q[0];
    rx_flush  = fcr_wr & (fcr_data[1] | en_toggle);
    tx_flush  = fcr_wr & (fcr_data[2] | en_toggle);
    ctrl_d    = fcr_wr ? (fcr_data & CTRL_KEEP) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign fcr_q = ctrl_q;
endmodule

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    push_ok = push & ~full;
    pop_ok  = pop & (cnt_q != '0);
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = wr_q + AW'(1);
      if (pop_ok)  rd_d = rd_q + AW'(1);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/uart_rxq_timer.sv
module uart_rxq_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rearm,
  input  logic             rd_hit,
  input  logic             tick,
  input  logic             has_data,
  input  logic [CNT_W-1:0] limit,
  output logic             pend
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             pend_q, pend_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    pend_d  = pend_q;
    if (clear) begin
      cnt_d   = '0;
      armed_d = 1'b0;
      pend_d  = 1'b0;
    end else begin
      if (rd_hit) pend_d = 1'b0;
      if (rearm) begin
        cnt_d   = '0;
        armed_d = 1'b1;
      end else if (armed_q && tick) begin
        if (cnt_q == limit - CNT_W'(1)) begin
          armed_d = 1'b0;
          if (has_data && !rd_hit) pend_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      pend_q  <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int OVERSAMPLE    = 16,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [3:0]        line_ctrl,
  input  logic              char_valid,
  input  logic [BYTE_W-1:0] char_data,
  input  logic              brk_valid,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              lsr_rd,
  input  logic              fcr_wr,
  input  logic [BYTE_W-1:0] fcr_data,
  output logic [BYTE_W-1:0] fcr_q,
  output logic              tx_flush,
  output logic              data_ready,
  output logic              overrun,
  output logic              brk_flag,
  output logic              trig_hit,
  output logic              timeout_pend,
  output logic [$clog2(DEPTH):0] fill_count
);
  localparam int CW        = $clog2(DEPTH) + 1;
  localparam int TPC       = OVERSAMPLE * TIMEOUT_CHARS;
  localparam int MAX_LIMIT = 12 * TPC;
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  logic              rx_flush, fifo_en, full, empty;
  logic              arrive, push, pop, rd_empties, ov_set, rearm;
  logic [BYTE_W-1:0] in_byte, head, hold_q, hold_d;
  logic              dr_q, dr_d, ov_q, ov_d, brk_q, brk_d;
  logic [CW-1:0]     trig_lvl;
  logic [CNT_W-1:0]  limit;
  trig_sel_e         trig_sel;

  uart_rxq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fcr_wr   (fcr_wr),
    .fcr_data (fcr_data),
    .fcr_q    (fcr_q),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  uart_rxq_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (push),
    .push_data (in_byte),
    .pop       (pop),
    .head      (head),
    .count     (fill_count),
    .full      (full)
  );

  uart_rxq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (rx_flush),
    .rearm    (rearm),
    .rd_hit   (rd_en),
    .tick     (baud_tick),
    .has_data (~empty),
    .limit    (limit),
    .pend     (timeout_pend)
  );

  always_comb begin
    fifo_en  = fcr_q[0];
    trig_sel = trig_sel_e'(fcr_q[7:6]);
    case (trig_sel)
      TRIG_ONE:  trig_lvl = CW'(1);
      TRIG_QTR:  trig_lvl = CW'(DEPTH / 4);
      TRIG_HALF: trig_lvl = CW'(DEPTH / 2);
      default:   trig_lvl = CW'(DEPTH - 2);
    endcase
    limit = CNT_W'(int'(frame_bits(line_ctrl)) * TPC);
  end

  always_comb begin
    empty      = (fill_count == '0);
    arrive     = char_valid | brk_valid;
    in_byte    = brk_valid ? '0 : char_data;
    push       = fifo_en & arrive & ~rx_flush;
    pop        = fifo_en & rd_en & ~empty & ~rx_flush;
    rd_empties = rd_en & (~fifo_en | (fill_count <= CW'(1)));
    ov_set     = arrive & ~rx_flush & (fifo_en ? full : dr_q);
    rearm      = fifo_en & ~rx_flush & (arrive | (rd_en & (fill_count > CW'(1))));

    hold_d = (!fifo_en && arrive && !rx_flush) ? in_byte : hold_q;
    ov_d   = ov_set | (ov_q & ~lsr_rd);

    if (rx_flush)        dr_d = 1'b0;
    else if (arrive)     dr_d = 1'b1;
    else if (rd_empties) dr_d = 1'b0;
    else                 dr_d = dr_q;

    if (rx_flush)                  brk_d = 1'b0;
    else if (brk_valid)            brk_d = 1'b1;
    else if (rd_empties || lsr_rd) brk_d = 1'b0;
    else                           brk_d = brk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      dr_q   <= 1'b0;
      ov_q   <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      dr_q   <= dr_d;
      ov_q   <= ov_d;
      brk_q  <= brk_d;
    end
  end

  assign rd_data    = fifo_en ? (empty ? '0 : head) : hold_q;
  assign data_ready = dr_q;
  assign overrun    = ov_q;
  assign brk_flag   = brk_q;
  assign trig_hit   = dr_q & (~fifo_en | (fill_count >= trig_lvl));
endmodule

// File: rtl/uart_rxq_checker.sv
module uart_rxq_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          char_valid,
  input logic          brk_valid,
  input logic          rd_en,
  input logic          fcr_wr,
  input logic [7:0]    fcr_data,
  input logic [7:0]    fcr_q,
  input logic          data_ready,
  input logic          overrun,
  input logic          timeout_pend,
  input logic [CW-1:0] fill_count
);
  assert_fill_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH));

  assert_full_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == CW'(DEPTH) && (char_valid || brk_valid) && !rd_en && !fcr_wr)
    |=> (fill_count == CW'(DEPTH) && overrun));

  assert_ready_tracks_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_q[0] |-> (data_ready == (fill_count != '0)));

  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_data[1]) |=> (fill_count == '0 && !data_ready && !timeout_pend));

  assert_toggle_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && (fcr_data[0] != fcr_q[0])) |=> (fill_count == '0));

  assert_read_drops_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !timeout_pend);

  assert_pend_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pend |-> (fill_count != '0));
endmodule

bind uart_rxq uart_rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .char_valid   (char_valid),
  .brk_valid    (brk_valid),
  .rd_en        (rd_en),
  .fcr_wr       (fcr_wr),
  .fcr_data     (fcr_data),
  .fcr_q        (fcr_q),
  .data_ready   (data_ready),
  .overrun      (overrun),
  .timeout_pend (timeout_pend),
  .fill_count   (fill_count)
);

// File: tb/tb_uart_rxq.sv
`timescale 1ns/1ps
module tb_uart_rxq;
  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic [3:0] line_ctrl;
  logic       char_valid;
  logic [7:0] char_data;
  logic       brk_valid;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       lsr_rd;
  logic       fcr_wr;
  logic [7:0] fcr_data;
  logic [7:0] fcr_q;
  logic       tx_flush;
  logic       data_ready, overrun, brk_flag, trig_hit, timeout_pend;
  logic [4:0] fill_count;

  uart_rxq dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int   n_chk;
  int   n_fail;
  bit   done;
  logic [7:0] exp_q [$];
  logic [7:0] m_hold;
  bit   m_fifo;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver tasks: stimulate and push expected bytes to the scoreboard.
  task automatic push_char(input logic [7:0] b, input bit brk);
    @(negedge clk);
    if (brk) brk_valid = 1'b1; else begin char_valid = 1'b1; char_data = b; end
    if (m_fifo) begin
      if (exp_q.size() < 16) exp_q.push_back(brk ? 8'h00 : b);
    end else begin
      m_hold = brk ? 8'h00 : b;
    end
    @(negedge clk);
    char_valid = 1'b0;
    brk_valid  = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic fcr_write(input logic [7:0] v, output logic txf);
    @(negedge clk);
    fcr_wr = 1'b1;
    fcr_data = v;
    #1 txf = tx_flush;
    if ((v[0] != m_fifo) || v[1]) exp_q.delete();
    m_fifo = v[0];
    @(negedge clk);
    fcr_wr = 1'b0;
  endtask

  task automatic lsr_pulse();
    @(negedge clk);
    lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
  endtask

  // Monitor: compare every read against the scoreboard.
  always @(negedge clk) begin
    #2;
    if (rd_en && rst_n) begin
      if (m_fifo) begin
        if (exp_q.size() > 0) chk("R5 read order", rd_data, exp_q.pop_front());
        else                  chk("R8 empty read", rd_data, 8'h00);
      end else begin
        chk("R12 holding read", rd_data, m_hold);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic txf;
    rst_n = 1'b0; baud_tick = 1'b0; line_ctrl = 4'h0;
    char_valid = 1'b0; char_data = 8'h00; brk_valid = 1'b0;
    rd_en = 1'b0; lsr_rd = 1'b0; fcr_wr = 1'b0; fcr_data = 8'h00;
    m_fifo = 1'b0; m_hold = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 fcr", fcr_q, 8'h00);
    chk("R1 fill", fill_count, 0);
    chk("R1 flags", {data_ready, overrun, brk_flag, trig_hit, timeout_pend}, 5'b0);

    // R2 mask, R3 toggle flush
    fcr_write(8'hFF, txf);
    chk("R3 toggle raises tx_flush", txf, 1);
    chk("R2 retained bits", fcr_q, 8'hC9);
    fcr_write(8'h01, txf);
    chk("R3 no toggle no flush", txf, 0);
    chk("R2 retained bits", fcr_q, 8'h01);

    // R4 level 1, R5 order
    push_char(8'h11, 0);
    chk("R4 level 1 trig", trig_hit, 1);
    push_char(8'h22, 0);
    push_char(8'h33, 0);
    chk("R5 fill", fill_count, 3);
    do_read(); do_read(); do_read();
    chk("R5 last read clears ready", data_ready, 0);

    // R4 other levels, R11 flush
    for (int s = 1; s < 4; s++) begin
      int lvl;
      lvl = (s == 1) ? 4 : (s == 2) ? 8 : 14;
      fcr_write({s[1:0], 6'h01}, txf);
      for (int i = 0; i < lvl - 1; i++) push_char(8'(8'h40 + i), 0);
      chk("R4 below level", trig_hit, 0);
      push_char(8'h7E, 0);
      chk("R4 at level", trig_hit, 1);
      fcr_write({s[1:0], 6'h03}, txf);
      chk("R11 flush empties", {fill_count, data_ready}, 6'b0);
    end
    fcr_write(8'h01, txf);

    // R6 overrun with full queue
    for (int i = 0; i < 16; i++) push_char(8'(8'hA0 + i), 0);
    chk("R6 full no overrun", {fill_count, overrun}, {5'd16, 1'b0});
    @(negedge clk); char_valid = 1'b1; char_data = 8'hEE;
    @(negedge clk); char_valid = 1'b0;
    chk("R6 dropped byte", {fill_count, overrun}, {5'd16, 1'b1});
    lsr_pulse();
    chk("R6 status read clears overrun", overrun, 0);
    for (int i = 0; i < 16; i++) do_read();
    chk("R6 drained", fill_count, 0);

    // R7 break
    push_char(8'h5A, 0);
    push_char(8'h00, 1);
    chk("R7 break flags", {fill_count, brk_flag, data_ready}, {5'd2, 1'b1, 1'b1});
    do_read();
    chk("R7 break held", brk_flag, 1);
    do_read();
    chk("R7 last read clears", {brk_flag, data_ready}, 2'b00);

    // R8 empty read
    do_read();

    // R9 timeout, 7-bit frame -> 448 ticks
    line_ctrl = 4'h0; baud_tick = 1'b1;
    push_char(8'h41, 0);
    repeat (447) @(negedge clk);
    chk("R9 before expiry", timeout_pend, 0);
    @(negedge clk);
    chk("R9 at expiry", timeout_pend, 1);
    do_read();
    chk("R8 read clears pend", timeout_pend, 0);
    repeat (500) @(negedge clk);
    chk("R9 no data no pend", timeout_pend, 0);

    // R10 rearm on arrival and on read leaving data
    push_char(8'h51, 0);
    push_char(8'h52, 0);
    repeat (300) @(negedge clk);
    push_char(8'h53, 0);
    repeat (447) @(negedge clk);
    chk("R10 arrival restarts window", timeout_pend, 0);
    @(negedge clk);
    chk("R10 expiry after arrival", timeout_pend, 1);
    do_read();
    repeat (447) @(negedge clk);
    chk("R10 read restarts window", timeout_pend, 0);
    @(negedge clk);
    chk("R10 expiry after read", timeout_pend, 1);
    fcr_write(8'h03, txf);
    chk("R11 flush clears pend", {timeout_pend, fill_count}, 6'b0);

    // R9 12-bit frame -> 768 ticks
    line_ctrl = 4'hF;
    push_char(8'h61, 0);
    repeat (767) @(negedge clk);
    chk("R9 long frame before", timeout_pend, 0);
    @(negedge clk);
    chk("R9 long frame expiry", timeout_pend, 1);
    fcr_write(8'h03, txf);
    baud_tick = 1'b0;

    // R12 holding register mode
    fcr_write(8'h00, txf);
    chk("R3 disable flush", txf, 1);
    push_char(8'h12, 0);
    chk("R12 ready", {data_ready, overrun, fill_count}, {1'b1, 1'b0, 5'd0});
    push_char(8'h34, 0);
    chk("R12 overrun", overrun, 1);
    do_read();
    chk("R12 read clears ready", data_ready, 0);
    lsr_pulse();
    chk("R12 overrun cleared", overrun, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule